// File: doc/BRIEF.md
# Programmable Edge and Polarity Conditioner

The conditioner takes a vector of asynchronous interrupt lines and turns each one into a conditioned request that a downstream enable bank can gate. Each line first passes through a two-flop synchroniser. A pair of configuration bits then sets what the line means, a "rise" bit and a "fall" bit. With the pair at 00 the line is a plain active-high level. At 11 it is an active-low level and is inverted. At 10 a rising edge raises a sticky event flag. At 01 a falling edge raises that flag.

Software sees the lines in banks of 32, one register window per bank, laid out at a bank stride of 0x20. The window base (0x200 in the surrounding chip) is decoded by the bus fabric. The `reg_addr` port carries only the offset inside the conditioner window. The configuration bits are changed only through set and clear strobe registers, where a one bit in the written data acts on its line. They can be read back directly. Latched edge events are acknowledged by writing ones to the raw-event register.

Top module: `edge_polarity_conditioner`

## Requirements
- R1: After a synchronous reset every rise and fall configuration bit is 0, which is level-high mode. No edge event is latched, and `cond_out` is 0 while the lines are low.
- R2: A line change reaches the synchronised value two clock edges later. In level-high mode `cond_out` follows the line with that two-edge delay.
- R3: The pair {rise,fall} selects the mode: 00 level-high, 10 rising edge, 01 falling edge, 11 level-low. In level-low mode `cond_out` is the inverted synchronised line.
- R4: Within a bank, word offsets 0x10, 0x14, 0x18 and 0x1C are rise-set, rise-clear, fall-set and fall-clear. Each one bit of the written data sets or clears the bit of its line, and zero bits leave their lines unchanged. Offsets 0x08 and 0x0C read back the rise and fall bits.
- R5: In an edge mode, a matching edge on the synchronised line sets the line's event flag three clock edges after the line changes. `cond_out` shows the flag, and the flag stays set after the line returns.
- R6: Writing to offset 0x04 clears every event flag of the bank whose data bit is 1 and leaves the others. Writing all ones clears the whole bank. A read of 0x04 returns the event flags.
- R7: When a new matching edge and a clear of the same flag fall in the same cycle, the flag stays set.
- R8: A line in a level mode latches no event, and its bit at offset 0x04 reads 0.
- R9: Offset 0x00 reads the bank's `cond_out` bits. Address bit 5 selects the bank, so lines 32 to 63 sit at the offsets plus 0x20. Address bits 1:0 are ignored, and the four strobe offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | NUM_LINES (64) | Asynchronous interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (6) | Byte offset inside the conditioner window |
| reg_wdata | input | BANK_W (32) | Write data |
| reg_rdata | output | BANK_W (32) | Read data for `reg_addr`, combinational |
| cond_out | output | NUM_LINES (64) | Conditioned request per line |

## Verification
The bench builds the block with its defaults: 64 lines in two banks of 32. This configuration puts the bank-select address bit and the upper window at 0x20 in play, alongside the lower one. Because every line carries its own rise and fall pair, random strobe writes leave lines in all four modes at once. The bench therefore checks edge latching, clears and level pass-through side by side, in both banks. Directed cases also place a clear in the same cycle as a fresh edge.

// File: rtl/epc_pkg.sv
// Package: shared encodings for the edge/polarity conditioner.
// Assumes a 32-bit-per-bank register window with word-aligned offsets.
package epc_pkg;

    // Word index within one bank (address bits 4:2)
    typedef enum logic [2:0] {
        SEL_STATUS   = 3'd0,
        SEL_RAW      = 3'd1,
        SEL_RISE     = 3'd2,
        SEL_FALL     = 3'd3,
        SEL_RISE_SET = 3'd4,
        SEL_RISE_CLR = 3'd5,
        SEL_FALL_SET = 3'd6,
        SEL_FALL_CLR = 3'd7
    } reg_sel_e;

    // Trigger mode, encoded as {rise, fall}
    typedef enum logic [1:0] {
        TRIG_LEVEL_HIGH = 2'b00,
        TRIG_FALLING    = 2'b01,
        TRIG_RISING     = 2'b10,
        TRIG_LEVEL_LOW  = 2'b11
    } trig_mode_e;

    localparam int WORD_LG2 = 2;
    localparam int SEL_W    = 3;
    localparam int BANK_LG2 = WORD_LG2 + SEL_W;   // bank stride 0x20

endpackage

// File: rtl/epc_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous lines.
// Assumes each line is individually meaningful (no bus coherency needed).
module epc_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two capture stages; reset to all-low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;

endmodule

// File: rtl/epc_cfg_bank.sv
// Module: rise/fall configuration bits of one bank, changed only through
// set/clear strobes. Assumes at most one strobe register is written per cycle.
module epc_cfg_bank
    import epc_pkg::*;
#(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [BANK_W-1:0] wr_data,
    output logic [BANK_W-1:0] rise_q,
    output logic [BANK_W-1:0] fall_q
);
    logic rise_set_stb, rise_clr_stb, fall_set_stb, fall_clr_stb;

    // Decode which strobe register is hit this cycle
    always_comb begin
        rise_set_stb = wr_en && (wr_sel == SEL_RISE_SET);
        rise_clr_stb = wr_en && (wr_sel == SEL_RISE_CLR);
        fall_set_stb = wr_en && (wr_sel == SEL_FALL_SET);
        fall_clr_stb = wr_en && (wr_sel == SEL_FALL_CLR);
    end

    // Rise bits: ones in the data set or clear their line
    always_ff @(posedge clk) begin
        if (!rst_n)            rise_q <= '0;
        else if (rise_set_stb) rise_q <= rise_q | wr_data;
        else if (rise_clr_stb) rise_q <= rise_q & ~wr_data;
    end

    // Fall bits: ones in the data set or clear their line
    always_ff @(posedge clk) begin
        if (!rst_n)            fall_q <= '0;
        else if (fall_set_stb) fall_q <= fall_q | wr_data;
        else if (fall_clr_stb) fall_q <= fall_q & ~wr_data;
    end

    // R4: a set strobe leaves every addressed rise bit high
    a_r4_rise_set: assert property (@(posedge clk) disable iff (!rst_n)
        rise_set_stb |=> ((rise_q & $past(wr_data)) == $past(wr_data)));
    // R4: a clear strobe leaves every addressed fall bit low, others untouched
    a_r4_fall_clr: assert property (@(posedge clk) disable iff (!rst_n)
        fall_clr_stb |=> (fall_q == ($past(fall_q) & ~$past(wr_data))));
    // R4: without a rise strobe the rise bits hold
    a_r4_rise_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_set_stb || rise_clr_stb) |=> $stable(rise_q));

endmodule

// File: rtl/epc_event_core.sv
// Module: per-line trigger decode, edge detection, sticky event flags and
// conditioned output for one bank. Assumes sync_in is already synchronised.
module epc_event_core
    import epc_pkg::*;
#(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] sync_in,
    input  logic [BANK_W-1:0] rise_cfg,
    input  logic [BANK_W-1:0] fall_cfg,
    input  logic [BANK_W-1:0] clr_mask,
    output logic [BANK_W-1:0] event_q,
    output logic [BANK_W-1:0] cond
);
    logic [BANK_W-1:0] prev_q;
    logic [BANK_W-1:0] hit;
    logic [BANK_W-1:0] lvl;
    logic [BANK_W-1:0] inv;

    // Previous synchronised sample, for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    for (genvar i = 0; i < BANK_W; i++) begin : g_line
        trig_mode_e mode;
        // Decode this line's mode and whether its selected edge occurred
        always_comb begin
            mode   = trig_mode_e'({rise_cfg[i], fall_cfg[i]});
            hit[i] = 1'b0;
            lvl[i] = 1'b0;
            inv[i] = 1'b0;
            case (mode)
                TRIG_RISING:     hit[i] = sync_in[i] & ~prev_q[i];
                TRIG_FALLING:    hit[i] = ~sync_in[i] & prev_q[i];
                TRIG_LEVEL_LOW:  begin lvl[i] = 1'b1; inv[i] = 1'b1; end
                default:         lvl[i] = 1'b1;
            endcase
        end
    end

    // Sticky flags: new edge beats clear; level lines hold nothing
    always_ff @(posedge clk) begin
        if (!rst_n) event_q <= '0;
        else        event_q <= ~lvl & (hit | (event_q & ~clr_mask));
    end

    // Conditioned request: level lines pass through, edge lines show the flag
    assign cond = (lvl & (sync_in ^ inv)) | (~lvl & event_q);

    // R5: a detected edge always leaves its flag set
    a_r5_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((event_q & $past(hit)) == $past(hit)));
    // R7: edge and clear together still leave the flag set
    a_r7_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit & clr_mask)) |=> ((event_q & $past(hit & clr_mask)) == $past(hit & clr_mask)));
    // R6: a clear without an edge drops the flag
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_mask & ~hit)) |=> ((event_q & $past(clr_mask & ~hit)) == '0));
    // R8: a line in a level mode holds no flag on the next cycle
    a_r8_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|lvl) |=> ((event_q & $past(lvl)) == '0));

endmodule

// File: rtl/epc_read_mux.sv
// Module: combinational register read selection across banks.
// Assumes NUM_BANKS is a power of two, matched by the width of bank_idx.
module epc_read_mux
    import epc_pkg::*;
#(
    parameter int BANK_W    = 32,
    parameter int NUM_BANKS = 2,
    localparam int BSEL_W   = $clog2(NUM_BANKS)
) (
    input  logic [BSEL_W-1:0]                 bank_idx,
    input  reg_sel_e                          sel,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] status_b,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] raw_b,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] rise_b,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] fall_b,
    output logic [BANK_W-1:0]                rdata
);
    // Pick the addressed word; strobe-only offsets read zero
    always_comb begin
        case (sel)
            SEL_STATUS: rdata = status_b[bank_idx];
            SEL_RAW:    rdata = raw_b[bank_idx];
            SEL_RISE:   rdata = rise_b[bank_idx];
            SEL_FALL:   rdata = fall_b[bank_idx];
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/edge_polarity_conditioner.sv
// Module: top of the edge/polarity conditioner. Synchronises the lines,
// holds per-line trigger configuration in banks, latches edge events and
// exposes a small register window. Assumes NUM_LINES is a multiple of
// BANK_W, at least two banks, and one register access per cycle.
module edge_polarity_conditioner
    import epc_pkg::*;
#(
    parameter int  NUM_LINES = 64,
    parameter int  BANK_W    = 32,
    localparam int NUM_BANKS = NUM_LINES / BANK_W,
    localparam int BSEL_W    = $clog2(NUM_BANKS),
    localparam int ADDR_W    = BANK_LG2 + BSEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [BANK_W-1:0]    reg_wdata,
    output logic [BANK_W-1:0]    reg_rdata,
    output logic [NUM_LINES-1:0] cond_out
);
    logic [NUM_LINES-1:0]             sync_lines;
    logic [BSEL_W-1:0]                bank_idx;
    reg_sel_e                         sel;
    logic [NUM_BANKS-1:0][BANK_W-1:0] status_b, raw_b, rise_b, fall_b;

    // Split the offset into bank index and word select
    always_comb begin
        bank_idx = reg_addr[ADDR_W-1:BANK_LG2];
        sel      = reg_sel_e'(reg_addr[BANK_LG2-1:WORD_LG2]);
    end

    epc_sync #(.W(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (line_in),
        .sync_out (sync_lines)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic              bank_wr;
        logic [BANK_W-1:0] clr_mask;

        // Write qualification and W1C mask for this bank
        always_comb begin
            bank_wr  = reg_wr && (bank_idx == BSEL_W'(b));
            clr_mask = (bank_wr && sel == SEL_RAW) ? reg_wdata : '0;
        end

        epc_cfg_bank #(.BANK_W(BANK_W)) u_cfg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr),
            .wr_sel  (sel),
            .wr_data (reg_wdata),
            .rise_q  (rise_b[b]),
            .fall_q  (fall_b[b])
        );

        epc_event_core #(.BANK_W(BANK_W)) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_in  (sync_lines[b*BANK_W +: BANK_W]),
            .rise_cfg (rise_b[b]),
            .fall_cfg (fall_b[b]),
            .clr_mask (clr_mask),
            .event_q  (raw_b[b]),
            .cond     (status_b[b])
        );

        assign cond_out[b*BANK_W +: BANK_W] = status_b[b];
    end

    epc_read_mux #(.BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS)) u_rd (
        .bank_idx (bank_idx),
        .sel      (sel),
        .status_b (status_b),
        .raw_b    (raw_b),
        .rise_b   (rise_b),
        .fall_b   (fall_b),
        .rdata    (reg_rdata)
    );

    // R1: the cycle after reset, no line requests from a latched event
    a_r1_reset_clean: assert property (@(posedge clk)
        !rst_n |=> (raw_b == '0));

endmodule

// File: tb/edge_polarity_conditioner_tb_top.sv
`timescale 1ns/1ps
module edge_polarity_conditioner_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] line_in;
    logic        reg_wr;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [63:0] cond_out;

    always #5 clk = ~clk;

    edge_polarity_conditioner dut_i (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cond_out(cond_out)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    string tag    = "R1";

    // Bench-side model state, from the requirements
    logic [63:0] m_s1, m_s2, m_prev, m_evt, m_rise, m_fall;
    logic [63:0] lines_now;

    function automatic logic [63:0] m_cond();
        logic [63:0] lvl;
        lvl = ~(m_rise ^ m_fall);
        return (lvl & (m_s2 ^ (m_rise & m_fall))) | (~lvl & m_evt);
    endfunction

    function automatic logic [31:0] m_read(input logic [5:0] a);
        logic [63:0] v;
        case (a[4:2])
            3'd0: v = m_cond();
            3'd1: v = m_evt;
            3'd2: v = m_rise;
            3'd3: v = m_fall;
            default: v = '0;
        endcase
        return a[5] ? v[63:32] : v[31:0];
    endfunction

    task automatic check(input string what, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_s1 = '0; m_s2 = '0; m_prev = '0; m_evt = '0; m_rise = '0; m_fall = '0;
    endtask

    // One clock: drive, check read before the edge, advance model, check output
    task automatic step(input logic [63:0] lines, input logic wr,
                        input logic [5:0] addr, input logic [31:0] data);
        logic [63:0] hr, hf, ev, lvl, clr, mask, n_evt, n_rise, n_fall;
        @(negedge clk);
        lines_now = lines;
        line_in = lines; reg_wr = wr; reg_addr = addr; reg_wdata = data;
        #1;
        check("read", {32'h0, reg_rdata}, {32'h0, m_read(addr)});
        hr   = m_s2 & ~m_prev;
        hf   = ~m_s2 & m_prev;
        ev   = (m_rise & ~m_fall & hr) | (~m_rise & m_fall & hf);
        lvl  = ~(m_rise ^ m_fall);
        mask = addr[5] ? {data, 32'h0} : {32'h0, data};
        clr  = (wr && addr[4:2] == 3'd1) ? mask : '0;
        n_evt  = ~lvl & (ev | (m_evt & ~clr));
        n_rise = m_rise; n_fall = m_fall;
        if (wr && addr[4:2] == 3'd4) n_rise = m_rise | mask;
        if (wr && addr[4:2] == 3'd5) n_rise = m_rise & ~mask;
        if (wr && addr[4:2] == 3'd6) n_fall = m_fall | mask;
        if (wr && addr[4:2] == 3'd7) n_fall = m_fall & ~mask;
        @(posedge clk);
        #1;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = lines;
        m_evt = n_evt; m_rise = n_rise; m_fall = n_fall;
        check("cond_out", cond_out, m_cond());
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(lines_now, 1'b0, 6'h00, 32'h0);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        step(lines_now, 1'b1, a, d);
    endtask

    task automatic rd(input logic [5:0] a);
        step(lines_now, 1'b0, a, 32'h0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1234_5eed));
        rst_n = 1'b0; line_in = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        lines_now = '0;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state of every readable word in both banks
        tag = "R1";
        for (int a = 0; a < 16; a++) rd(6'(a * 4));
        check("R1 cond_out zero", cond_out, 64'h0);

        // R2: level-high pass-through with two-edge latency
        tag = "R2";
        step(64'h1, 1'b0, 6'h00, 0);
        check("R2 after one edge", {63'h0, cond_out[0]}, 64'h0);
        step(64'h1, 1'b0, 6'h00, 0);
        check("R2 after two edges", {63'h0, cond_out[0]}, 64'h1);
        step(64'h0, 1'b0, 6'h00, 0);
        idle(2);

        // R4: set/clear strobes; line0 rising, line1 falling, line2 level-low
        tag = "R4";
        wr(6'h10, 32'h5);      // rise set lines 0,2
        wr(6'h18, 32'h6);      // fall set lines 1,2
        wr(6'h10, 32'h8);      // rise set line 3
        wr(6'h14, 32'h8);      // rise clear line 3
        rd(6'h08);
        check("R4 rise readback", {32'h0, reg_rdata}, 64'h5);
        rd(6'h0C);
        check("R4 fall readback", {32'h0, reg_rdata}, 64'h6);
        rd(6'h0B);             // low address bits ignored (R9)

        // R3: level-low inverts (line2 low -> request high)
        tag = "R3";
        idle(1);
        check("R3 level-low inverted", {63'h0, cond_out[2]}, 64'h1);
        step(64'h4, 1'b0, 6'h00, 0);
        idle(1);
        check("R3 level-low deasserts", {63'h0, cond_out[2]}, 64'h0);
        step(64'h0, 1'b0, 6'h00, 0);
        idle(2);

        // R5: rising edge on line0 latches on the third edge and sticks
        tag = "R5";
        step(64'h3, 1'b0, 6'h00, 0);   // lines 0 and 1 high
        check("R5 edge 1", {63'h0, cond_out[0]}, 64'h0);
        idle(1);
        check("R5 edge 2", {63'h0, cond_out[0]}, 64'h0);
        idle(1);
        check("R5 edge 3 latched", {63'h0, cond_out[0]}, 64'h1);
        check("R5 rising ignored on falling line", {63'h0, cond_out[1]}, 64'h0);
        step(64'h0, 1'b0, 6'h00, 0);
        idle(3);
        check("R5 sticky after line drops", {63'h0, cond_out[0]}, 64'h1);
        check("R5 falling edge latched", {63'h0, cond_out[1]}, 64'h1);
        rd(6'h04);
        check("R5 raw readback", {32'h0, reg_rdata}, 64'h3);

        // R6: W1C clears only addressed flags, then all ones
        tag = "R6";
        wr(6'h04, 32'h2);
        check("R6 partial clear keeps line0", cond_out[1:0], 64'h1);
        wr(6'h04, 32'hFFFF_FFFF);
        check("R6 clear all", cond_out[1:0], 64'h0);

        // R7: edge and clear in the same cycle; edge wins
        tag = "R7";
        step(64'h1, 1'b0, 6'h00, 0);
        idle(1);
        wr(6'h04, 32'h1);              // hit present this cycle
        check("R7 edge beats clear", {63'h0, cond_out[0]}, 64'h1);
        wr(6'h04, 32'h1);
        check("R7 later clear works", {63'h0, cond_out[0]}, 64'h0);

        // R8: level lines never latch; raw word shows zero
        tag = "R8";
        step(64'h5, 1'b0, 6'h00, 0);   // line2 level-low toggles too
        step(64'h1, 1'b0, 6'h00, 0);
        idle(3);
        rd(6'h04);
        check("R8 level line raw zero", {63'h0, reg_rdata[2]}, 64'h0);

        // R9: upper bank at +0x20, line32 rising
        tag = "R9";
        wr(6'h30, 32'h1);
        step(64'h1_0000_0001, 1'b0, 6'h00, 0);
        idle(3);
        rd(6'h20);
        check("R9 upper status", {63'h0, reg_rdata[0]}, 64'h1);
        rd(6'h24);
        check("R9 upper raw", {63'h0, reg_rdata[0]}, 64'h1);
        rd(6'h04);
        check("R9 lower raw untouched", {63'h0, reg_rdata[0]}, 64'h0);
        rd(6'h30);
        check("R9 strobe reads zero", {32'h0, reg_rdata}, 64'h0);

        // Random mix: all modes across both banks (R3/R5/R6 by model)
        tag = "R3";
        for (int n = 0; n < 4000; n++) begin
            logic [63:0] flip;
            logic [5:0]  a;
            logic [31:0] d;
            flip = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
            a    = 6'($urandom_range(0, 15) * 4);
            d    = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
            step(lines_now ^ flip, ($urandom_range(0, 4) == 0), a, d);
        end

        finish_run();
    end

endmodule